// File: doc/BRIEF.md
# 64b/66b Transmit Block Encoder

The encoder takes one 64-bit word per accepted cycle, with an 8-bit mask holding one flag per byte that marks the byte as control, and produces a 66-bit line block. The low two bits of the block are a sync header. The header is 01 when every byte is plain data and 10 when at least one byte is flagged as control. Because the header is always 01 or 10, every block carries at least one transition.

The 64 payload bits go through a self-synchronous scrambler with polynomial x^58 + x^39 + 1. The scrambler runs one bit per step, starting from bit 0. All 64 steps are unrolled into a single cycle. Each scrambled bit is shifted back into the scrambler state. The header does not pass through the scrambler. Control bytes are not transcoded; they are scrambled exactly like data bytes. The input side uses a valid/ready handshake. The output is a registered block with a valid strobe.

Top module: `enc66_tx`

## Requirements
- R1: While rst_ni is low, out_valid_o, in_ready_o and block_o are all zero.
- R2: A word accepted with ctrl_i equal to zero gives block_o[1:0] == 2'b01.
- R3: A word accepted with any bit of ctrl_i set gives block_o[1:0] == 2'b10, whichever byte position is flagged.
- R4: On every valid block, block_o[1] differs from block_o[0].
- R5: Payload bits block_o[65:2] hold the scrambled word. Scrambled bit i is p[i] = d[i] ^ s[38] ^ s[57], processed for i = 0 up to 63. After each step the state shifts to s = {s[56:0], p[i]}.
- R6: After reset the scrambler state is all ones. As a result, an all-zero first word gives payload bits 0 to 38 equal to 0 and payload bit 39 equal to 1.
- R7: The scrambler state advances only on accepted words. Idle cycles between words do not change the payload that the next word produces.
- R8: out_valid_o is high exactly in the cycle after a word is accepted (in_valid_i && in_ready_o). While out_valid_o is low, block_o holds its previous value.
- R9: in_ready_o goes high at the first clock edge after reset is released and stays high. This allows one word to be accepted per cycle, back to back.
- R10: Control flags only affect the header. A word flagged as all control produces the same payload as the same word sent as data from the same scrambler state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word is valid |
| in_ready_o | output | 1 | Encoder can accept a word |
| data_i | input | 64 | Input word, byte 0 in bits [7:0] |
| ctrl_i | input | 8 | Per-byte control flags, bit k covers byte k |
| out_valid_o | output | 1 | block_o holds a new block |
| block_o | output | 66 | Header in [1:0], scrambled payload in [65:2] |

## Verification
The bench builds the encoder with its default parameters: a 64-bit word and scrambler taps at 39 and 58. Because 64 is larger than 58, bits scrambled early in a word feed back into the later bits of the same word. This makes the unrolled feedback chain inside one cycle observable. The all-ones reset state is observable in the first word after each reset. A reset in the middle of the run, gaps between words and back-to-back streaming exercise the rule that the state advances only on acceptance. A flagged control byte is walked through every byte position to cover each input of the header reduction.

// File: rtl/enc66_pkg.sv
package enc66_pkg;
  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [1:0] HDR_CTRL = 2'b10;
endpackage

// File: rtl/enc66_hdr_sel.sv
module enc66_hdr_sel #(
  parameter int BYTES = 8
) (
  input  logic [BYTES-1:0] ctrl_i,
  output logic [1:0]       hdr_o
);
  import enc66_pkg::*;
  always_comb hdr_o = (|ctrl_i) ? HDR_CTRL : HDR_DATA;
endmodule

// File: rtl/enc66_scrambler.sv
module enc66_scrambler #(
  parameter int DATA_W   = 64,
  parameter int TAP_NEAR = 39,
  parameter int TAP_FAR  = 58
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] scr_o
);
  logic [TAP_FAR-1:0] state_q, state_d;

  // bit 0 first; each output bit is shifted into the state
  always_comb begin
    state_d = state_q;
    scr_o   = '0;
    for (int i = 0; i < DATA_W; i++) begin
      scr_o[i] = data_i[i] ^ state_d[TAP_NEAR-1] ^ state_d[TAP_FAR-1];
      state_d  = {state_d[TAP_FAR-2:0], scr_o[i]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '1;
    else if (adv_i) state_q <= state_d;
  end

  // R7
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));
endmodule

// File: rtl/enc66_tx.sv
module enc66_tx #(
  parameter int DATA_W   = 64,
  parameter int TAP_NEAR = 39,
  parameter int TAP_FAR  = 58,
  localparam int BYTES   = DATA_W / 8,
  localparam int BLK_W   = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BYTES-1:0]  ctrl_i,
  output logic              out_valid_o,
  output logic [BLK_W-1:0]  block_o
);
  logic              ready_q, accept, out_valid_q;
  logic [1:0]        hdr;
  logic [DATA_W-1:0] scr;
  logic [BLK_W-1:0]  block_q;

  assign accept = in_valid_i & ready_q;

  enc66_hdr_sel #(.BYTES(BYTES)) u_hdr (
    .ctrl_i (ctrl_i),
    .hdr_o  (hdr)
  );

  enc66_scrambler #(.DATA_W(DATA_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (accept),
    .data_i (data_i),
    .scr_o  (scr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q     <= 1'b0;
      out_valid_q <= 1'b0;
      block_q     <= '0;
    end else begin
      ready_q     <= 1'b1;
      out_valid_q <= accept;
      if (accept) block_q <= {scr, hdr};
    end
  end

  assign in_ready_o  = ready_q;
  assign out_valid_o = out_valid_q;
  assign block_o     = block_q;

  // R8
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i && in_ready_o));
  // R8
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(block_o));
  // R2 R3
  hdr_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> block_o[1:0] == ($past(|ctrl_i) ? 2'b10 : 2'b01));
  // R4
  hdr_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> block_o[1] != block_o[0]);
  // R9
  ready_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> in_ready_o);
endmodule

// File: tb/enc66_tx_bench.sv
`timescale 1ns/1ps
module enc66_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] data = '0;
  logic [7:0]  ctrl = '0;
  logic        out_valid;
  logic [65:0] block;

  int total = 0;
  int bad   = 0;
  logic [57:0] m_st;

  always #10 clk = ~clk;

  enc66_tx u_enc66_tx (
    .clk_i (clk), .rst_ni (rst_n),
    .in_valid_i (in_valid), .in_ready_o (in_ready),
    .data_i (data), .ctrl_i (ctrl),
    .out_valid_o (out_valid), .block_o (block)
  );

  task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] d, input logic [7:0] c, output logic [65:0] blk);
    logic [63:0] p;
    for (int i = 0; i < 64; i++) begin
      p[i] = d[i] ^ m_st[38] ^ m_st[57];
      m_st = {m_st[56:0], p[i]};
    end
    blk = {p, (|c) ? 2'b10 : 2'b01};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    m_st = '1;
    #1;
    chk("R1 valid", {65'b0, out_valid}, 66'b0);
    chk("R1 ready", {65'b0, in_ready}, 66'b0);
    chk("R1 block", block, 66'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready", {65'b0, in_ready}, 66'd1);
  endtask

  // one word, checked in the cycle after acceptance
  task automatic send(input string req, input logic [63:0] d, input logic [7:0] c,
                      output logic [65:0] got);
    logic [65:0] exp;
    model(d, c, exp);
    in_valid = 1'b1; data = d; ctrl = c;
    @(negedge clk);
    in_valid = 1'b0;
    got = block;
    chk({req, " valid"}, {65'b0, out_valid}, 66'd1);
    chk(req, block, exp);
  endtask

  task automatic t_first_zero();
    logic [65:0] g;
    do_reset();
    send("R2 R5", 64'h0, 8'h00, g);
    chk("R6 low bits", {27'b0, g[40:2]}, 66'b0);
    chk("R6 bit39", {65'b0, g[41]}, 66'd1);
    chk("R2 hdr", {64'b0, g[1:0]}, 66'b01);
  endtask

  task automatic t_ctrl_walk();
    logic [65:0] g;
    for (int k = 0; k < 8; k++) begin
      send("R3 R5", 64'h0123_4567_89ab_cdef ^ (64'(k) << 8*k), 8'(1 << k), g);
      chk("R3 hdr", {64'b0, g[1:0]}, 66'b10);
      chk("R4 edge", {65'b0, g[1] ^ g[0]}, 66'd1);
    end
  endtask

  task automatic t_gap();
    logic [65:0] g;
    send("R5", 64'hdead_beef_0bad_f00d, 8'h00, g);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      data = ~data; ctrl = 8'hff;
      chk("R8 idle valid", {65'b0, out_valid}, 66'b0);
      chk("R8 hold", block, g);
    end
    send("R7 after gap", 64'hfeed_face_cafe_babe, 8'h00, g);
  endtask

  task automatic t_ctrl_raw();
    logic [65:0] a, b;
    do_reset();
    send("R10 data", 64'h5555_aaaa_3333_cccc, 8'h00, a);
    do_reset();
    send("R10 ctrl", 64'h5555_aaaa_3333_cccc, 8'hff, b);
    chk("R10 payload", {2'b0, b[65:2]}, {2'b0, a[65:2]});
  endtask

  task automatic t_stream();
    logic [65:0] exp;
    logic [63:0] d;
    logic [7:0]  c;
    do_reset();
    for (int k = 0; k <= 20; k++) begin
      if (k > 0) begin
        chk("R9 R8 stream valid", {65'b0, out_valid}, 66'd1);
        chk("R5 stream", block, exp);
      end
      if (k < 20) begin
        d = {32'(k) * 32'h9e37_79b9, ~(32'(k) * 32'h85eb_ca6b)};
        c = (k % 3 == 0) ? 8'(k) : 8'h00;
        model(d, c, exp);
        in_valid = 1'b1; data = d; ctrl = c;
      end else in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    m_st = '1;
    t_first_zero();
    t_ctrl_walk();
    t_gap();
    t_ctrl_raw();
    t_stream();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule